// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines from peripherals and turns them into two processor-facing signals: a fast-interrupt line and a normal-interrupt line. Software places each request line in one of three classes. A fast-class line drives the fast-interrupt output directly. A vectored line is bound to one of 16 priority slots; each slot carries its own handler address. Any other enabled line is non-vectored and is served through a single default address.

The processor's handler entry reads the vector register. That read returns the address of the best pending slot, or the default address when only non-vectored work is pending. The read also records the winning level as in service, which holds off equal and lower priority work until software writes the acknowledge register. Higher slots can still interrupt a level that is in service, and the in-service levels nest as a stack. The register interface uses word addresses, has single-cycle writes, and returns read data combinationally from the current address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Address 0x02 holds one class bit per source, where 1 selects the fast class. `fiq_o` is high in the same cycle whenever any request is high, enabled, and in the fast class. Address 0x08 reads back those fast pending bits.
- R2: A fast-class source never drives `irq_o` and never selects a vector, even when an enabled slot names it.
- R3: A write to 0x03 sets the enable bits that are 1 in the data. A write to 0x04 clears the enable bits that are 1 in the data. Reading 0x03 returns the enable mask. A disabled request affects neither output nor the vector.
- R4: Address 0x00 returns the raw request lines. Address 0x01 returns the requests ANDed with the enable mask.
- R5: Slot k has a control word at address 0x40+k: bit 5 enables the slot and bits 4:0 name its source. Among the eligible slots whose source is pending, enabled and not fast, the lowest index wins. Rewriting a slot's control word changes the winner in the next cycle.
- R6: A read of 0x05 returns the address word of the winning slot, stored at 0x80+k.
- R7: A non-vectored source is enabled, not fast, and named by no enabled slot. If no slot wins but such a source is pending and eligible, `irq_o` is high and 0x05 returns the default address held at 0x07. When nothing is pending, 0x05 also returns the default address.
- R8: `irq_o` is high exactly when an eligible slot wins or an eligible non-vectored source is pending.
- R9: A read of 0x05 while `irq_o` is high puts the winning level in service. Non-vectored work counts as level 16, below every slot. Until that level is retired, only slots with a smaller index stay eligible. A read while `irq_o` is low changes nothing.
- R10: Any write to 0x06 retires the highest-priority level that is in service. This returns eligibility to the level that was in service before it.
- R11: After reset, all registers read 0, no level is in service, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Level-sensitive request lines, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on the vector register) |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
The vector is read under several request mixes. These are: a fast line named by a slot next to an unclaimed line, which separates class exclusion from default routing; two pending slots, which shows the lower index wins; and a slot rewritten to an idle source, which shows that priority changes at run time. The nesting case takes a low slot into service, raises a higher slot, reads again, and then acknowledges twice. This tells a stack of in-service levels apart from a single latch. Each cycle, a reference model built on a queue of in-service levels predicts both outputs and every read value.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int SRC_W  = 5;
    localparam int SRC_MAX = 1 << SRC_W;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] REG_RAW      = 8'h00;
    localparam logic [ADDR_W-1:0] REG_MASKED   = 8'h01;
    localparam logic [ADDR_W-1:0] REG_CLASS    = 8'h02;
    localparam logic [ADDR_W-1:0] REG_EN_SET   = 8'h03;
    localparam logic [ADDR_W-1:0] REG_EN_CLR   = 8'h04;
    localparam logic [ADDR_W-1:0] REG_VECT     = 8'h05;
    localparam logic [ADDR_W-1:0] REG_ACK      = 8'h06;
    localparam logic [ADDR_W-1:0] REG_DFLT     = 8'h07;
    localparam logic [ADDR_W-1:0] REG_FAST     = 8'h08;
    localparam logic [ADDR_W-1:0] REG_SLOT_CTL = 8'h40;
    localparam logic [ADDR_W-1:0] REG_SLOT_VEC = 8'h80;

    localparam int SLOT_EN_BIT = SRC_W;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } slot_ctl_t;

    typedef enum logic [1:0] {
        VK_NONE,
        VK_SLOT,
        VK_DEFAULT
    } vec_kind_t;

    function automatic logic addr_in(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input int n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
    import ivc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   en_mask,
    output logic [NSRC-1:0]   fast_sel,
    output logic [DATA_W-1:0] dflt_vec,
    output slot_ctl_t         slot_ctl [NSLOT],
    output logic [DATA_W-1:0] slot_vec [NSLOT],
    output logic              ack_wr
);

    logic [NSRC-1:0] wbits;
    assign wbits  = wdata[NSRC-1:0];
    assign ack_wr = wr && (addr == REG_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask  <= '0;
            fast_sel <= '0;
            dflt_vec <= '0;
        end else if (wr) begin
            case (addr)
                REG_CLASS:  fast_sel <= wbits;
                REG_EN_SET: en_mask  <= en_mask | wbits;
                REG_EN_CLR: en_mask  <= en_mask & ~wbits;
                REG_DFLT:   dflt_vec <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NSLOT; k++) begin
            if (rst) begin
                slot_ctl[k] <= '0;
                slot_vec[k] <= '0;
            end else if (wr) begin
                if (addr == REG_SLOT_CTL + ADDR_W'(k))
                    slot_ctl[k] <= slot_ctl_t'(wdata[SLOT_EN_BIT:0]);
                if (addr == REG_SLOT_VEC + ADDR_W'(k))
                    slot_vec[k] <= wdata;
            end
        end
    end

endmodule

// File: rtl/ivc_prio.sv
module ivc_prio
    import ivc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    localparam int LVL_W = $clog2(NSLOT + 2)
) (
    input  logic [NSRC-1:0]  vec_pend,
    input  slot_ctl_t        slot_ctl [NSLOT],
    input  logic [LVL_W-1:0] thresh,
    output logic             win_valid,
    output logic [LVL_W-1:0] win_level,
    output logic             nv_pend
);

    logic [SRC_MAX-1:0] pend_pad;
    logic [SRC_MAX-1:0] claimed;
    logic [NSLOT-1:0]   slot_hit;

    assign pend_pad = SRC_MAX'(vec_pend);

    generate
        for (genvar k = 0; k < NSLOT; k++) begin : g_slot
            assign slot_hit[k] = slot_ctl[k].en
                              && pend_pad[slot_ctl[k].src]
                              && (LVL_W'(k) < thresh);
        end
    endgenerate

    always_comb begin
        claimed = '0;
        for (int k = 0; k < NSLOT; k++)
            if (slot_ctl[k].en) claimed[slot_ctl[k].src] = 1'b1;
    end

    always_comb begin
        win_valid = 1'b0;
        win_level = LVL_W'(NSLOT);
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (slot_hit[k]) begin
                win_valid = 1'b1;
                win_level = LVL_W'(k);
            end
        end
    end

    assign nv_pend = (|(pend_pad & ~claimed)) && (LVL_W'(NSLOT) < thresh);

endmodule

// File: rtl/ivc_svc.sv
module ivc_svc #(
    parameter int NSLOT = 16,
    localparam int NLVL  = NSLOT + 1,
    localparam int LVL_W = $clog2(NSLOT + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LVL_W-1:0] take_level,
    input  logic             retire,
    output logic [NLVL-1:0]  svc_mask,
    output logic [LVL_W-1:0] thresh
);

    logic [NLVL-1:0] lowest;
    assign lowest = svc_mask & (~svc_mask + NLVL'(1));

    always_comb begin
        thresh = LVL_W'(NLVL);
        for (int k = NLVL - 1; k >= 0; k--)
            if (svc_mask[k]) thresh = LVL_W'(k);
    end

    always_ff @(posedge clk) begin
        if (rst)
            svc_mask <= '0;
        else if (retire)
            svc_mask <= svc_mask & ~lowest;
        else if (take)
            svc_mask <= svc_mask | (NLVL'(1) << take_level);
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fiq_o,
    output logic              irq_o
);

    localparam int NLVL       = NSLOT + 1;
    localparam int LVL_W      = $clog2(NSLOT + 2);
    localparam int SLOT_IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [NSRC-1:0]   en_mask, fast_sel, masked, fast_pend, vec_pend;
    logic [DATA_W-1:0] dflt_vec;
    slot_ctl_t         slot_ctl [NSLOT];
    logic [DATA_W-1:0] slot_vec [NSLOT];
    logic              ack_wr, win_valid, nv_pend, take;
    logic [LVL_W-1:0]  win_level, thresh, take_level;
    logic [NLVL-1:0]   svc_mask;
    vec_kind_t         vkind;
    logic [DATA_W-1:0] vector_q;

    ivc_regs #(.NSRC(NSRC), .NSLOT(NSLOT)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .en_mask(en_mask), .fast_sel(fast_sel), .dflt_vec(dflt_vec),
        .slot_ctl(slot_ctl), .slot_vec(slot_vec), .ack_wr(ack_wr)
    );

    assign masked    = irq_req & en_mask;
    assign fast_pend = masked & fast_sel;
    assign vec_pend  = masked & ~fast_sel;
    assign fiq_o     = |fast_pend;

    ivc_prio #(.NSRC(NSRC), .NSLOT(NSLOT)) u_prio (
        .vec_pend(vec_pend), .slot_ctl(slot_ctl), .thresh(thresh),
        .win_valid(win_valid), .win_level(win_level), .nv_pend(nv_pend)
    );

    assign irq_o = win_valid | nv_pend;

    always_comb begin
        if (win_valid)    vkind = VK_SLOT;
        else if (nv_pend) vkind = VK_DEFAULT;
        else              vkind = VK_NONE;
    end

    always_comb begin
        case (vkind)
            VK_SLOT: vector_q = slot_vec[win_level[SLOT_IDX_W-1:0]];
            default: vector_q = dflt_vec;
        endcase
    end

    assign take       = bus_rd && (bus_addr == REG_VECT) && (vkind != VK_NONE);
    assign take_level = (vkind == VK_SLOT) ? win_level : LVL_W'(NSLOT);

    ivc_svc #(.NSLOT(NSLOT)) u_svc (
        .clk(clk), .rst(rst), .take(take), .take_level(take_level),
        .retire(ack_wr), .svc_mask(svc_mask), .thresh(thresh)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_RAW:    bus_rdata = DATA_W'(irq_req);
            REG_MASKED: bus_rdata = DATA_W'(masked);
            REG_CLASS:  bus_rdata = DATA_W'(fast_sel);
            REG_EN_SET: bus_rdata = DATA_W'(en_mask);
            REG_VECT:   bus_rdata = vector_q;
            REG_DFLT:   bus_rdata = dflt_vec;
            REG_FAST:   bus_rdata = DATA_W'(fast_pend);
            default: begin
                if (addr_in(bus_addr, REG_SLOT_CTL, NSLOT) ||
                    addr_in(bus_addr, REG_SLOT_VEC, NSLOT)) begin
                    for (int k = 0; k < NSLOT; k++) begin
                        if (bus_addr == REG_SLOT_CTL + ADDR_W'(k))
                            bus_rdata = DATA_W'(slot_ctl[k]);
                        if (bus_addr == REG_SLOT_VEC + ADDR_W'(k))
                            bus_rdata = slot_vec[k];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   irq_req,
    input logic              fiq_o,
    input logic              irq_o,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   en_mask,
    input logic [NSRC-1:0]   fast_sel,
    input logic [NSLOT:0]    svc_mask
);

    // R1: a fast interrupt needs a pending request of the fast class
    p_fiq_source_r1: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> ((irq_req & fast_sel) != '0));

    // R8: a normal interrupt needs an enabled, non-fast request
    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((irq_req & en_mask & ~fast_sel) != '0));

    // R3: set-bit write leaves those bits enabled
    p_en_set_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_EN_SET) |=>
        ((en_mask & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R3: clear-bit write leaves those bits disabled
    p_en_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_EN_CLR) |=>
        ((en_mask & $past(bus_wdata[NSRC-1:0])) == '0));

    // R9: an effective vector read adds exactly one in-service level
    p_take_level_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG_VECT && irq_o && !(bus_wr && bus_addr == REG_ACK)) |=>
        ($countones(svc_mask) == $past($countones(svc_mask)) + 1));

    // R10: acknowledge retires exactly one level when any is held
    p_ack_retire_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_ACK && svc_mask != '0) |=>
        ($countones(svc_mask) == $past($countones(svc_mask)) - 1));

endmodule

bind irq_vector_ctrl ivc_checker #(.NSRC(NSRC), .NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .fiq_o(fiq_o), .irq_o(irq_o),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .en_mask(en_mask), .fast_sel(fast_sel), .svc_mask(svc_mask)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req = '0;
    logic        bwr = 1'b0, brd = 1'b0;
    logic [7:0]  baddr = '0;
    logic [31:0] bwdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq;

    int checks = 0, errors = 0;
    bit running = 0;

    bit [31:0] m_en, m_cls, m_dflt;
    bit        m_sen [16];
    int        m_ssrc[16];
    bit [31:0] m_sadr[16];
    int        svc[$];

    always #(PERIOD/2) clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst(rst), .irq_req(req), .bus_wr(bwr), .bus_rd(brd),
        .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rdata),
        .fiq_o(fiq), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model(input bit [31:0] r, output bit f, output bit i,
                                  output bit [31:0] v, output int lvl);
        int thr, win;
        bit [31:0] pend, claimed;
        thr = (svc.size() > 0) ? svc[0] : 17;
        pend = r & m_en & ~m_cls;
        f = |(r & m_en & m_cls);
        claimed = '0;
        for (int k = 0; k < 16; k++) if (m_sen[k]) claimed[m_ssrc[k]] = 1'b1;
        win = -1;
        for (int k = 0; k < 16; k++)
            if (win < 0 && k < thr && m_sen[k] && pend[m_ssrc[k]]) win = k;
        if (win >= 0) begin
            i = 1; v = m_sadr[win]; lvl = win;
        end else begin
            i = (|(pend & ~claimed)) && (16 < thr); v = m_dflt; lvl = 16;
        end
    endfunction

    function automatic bit [31:0] model_reg(input bit [7:0] a, input bit [31:0] v);
        case (a)
            8'h00: return req;
            8'h01: return req & m_en;
            8'h02: return m_cls;
            8'h03: return m_en;
            8'h05: return v;
            8'h07: return m_dflt;
            8'h08: return req & m_en & m_cls;
            default: begin
                if (a >= 8'h40 && a < 8'h50) return {26'd0, m_sen[a-8'h40], 5'(m_ssrc[a-8'h40])};
                if (a >= 8'h80 && a < 8'h90) return m_sadr[a-8'h80];
                return '0;
            end
        endcase
    endfunction

    always @(negedge clk) begin
        if (running && !rst) begin
            bit f, i; bit [31:0] v; int l;
            model(req, f, i, v, l);
            check("R1 fiq_o", 32'(fiq), 32'(f));
            check("R8 irq_o", 32'(irq), 32'(i));
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(posedge clk); #1; bwr = 1; baddr = a; bwdata = d;
        @(posedge clk); #1; bwr = 0;
        case (a)
            8'h02: m_cls = d;
            8'h03: m_en = m_en | d;
            8'h04: m_en = m_en & ~d;
            8'h06: if (svc.size() > 0) void'(svc.pop_front());
            8'h07: m_dflt = d;
            default: begin
                if (a >= 8'h40 && a < 8'h50) begin
                    m_sen[a-8'h40] = d[5]; m_ssrc[a-8'h40] = int'(d[4:0]);
                end
                if (a >= 8'h80 && a < 8'h90) m_sadr[a-8'h80] = d;
            end
        endcase
    endtask

    task automatic rd(input bit [7:0] a, input string tag);
        bit f, i; bit [31:0] v; int l;
        @(posedge clk); #1; brd = 1; baddr = a;
        @(negedge clk);
        model(req, f, i, v, l);
        check(tag, rdata, model_reg(a, v));
        @(posedge clk); #1; brd = 0;
        if (a == 8'h05 && i) svc.push_front(l);
    endtask

    task automatic setreq(input bit [31:0] v);
        @(posedge clk); #1; req = v;
    endtask

    task automatic outs(input string tag, input bit ef, input bit ei);
        @(negedge clk);
        check({tag, " fiq"}, 32'(fiq), 32'(ef));
        check({tag, " irq"}, 32'(irq), 32'(ei));
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) begin m_sen[k] = 0; m_ssrc[k] = 0; m_sadr[k] = 0; end
        m_en = 0; m_cls = 0; m_dflt = 0;
        repeat (3) @(posedge clk);
        #1; rst = 0; running = 1;
        // R11 reset state
        outs("R11", 0, 0);
        rd(8'h03, "R11 enable"); rd(8'h02, "R11 class");
        rd(8'h05, "R11 vector"); rd(8'h40, "R11 slot0"); rd(8'h07, "R11 default");
        // R3 / R4 enable and status
        wr(8'h03, 32'hFF); wr(8'h04, 32'h0F);
        rd(8'h03, "R3 enable mask");
        setreq(32'h33);
        rd(8'h00, "R4 raw"); rd(8'h01, "R4 masked");
        // R7 default vector for non-vectored
        wr(8'h07, 32'hDEAD_0000);
        outs("R7", 0, 1);
        rd(8'h05, "R7 default vector");
        outs("R9 nonvec in service", 0, 0);
        wr(8'h06, 0);
        outs("R10 ack", 0, 1);
        // R1 / R2 fast class
        wr(8'h02, 32'h10);
        outs("R1", 1, 1);
        rd(8'h08, "R1 fast status");
        wr(8'h80, 32'h0000_1000); wr(8'h40, 32'h20 | 4);
        rd(8'h05, "R2 fast slot ignored");
        wr(8'h06, 0);
        // R5 / R6 slot priority
        wr(8'h03, 32'h0010_2000);
        wr(8'h83, 32'h0000_3000); wr(8'h43, 32'h20 | 5);
        wr(8'h87, 32'h0000_7000); wr(8'h47, 32'h20 | 13);
        setreq(32'h2033);
        rd(8'h05, "R6 slot3 vector");
        outs("R9 lower masked", 1, 0);
        wr(8'h06, 0);
        wr(8'h43, 32'h20 | 20);
        rd(8'h43, "R5 slot ctl");
        rd(8'h05, "R5 reassigned winner");
        // R9 nesting
        wr(8'h81, 32'h0000_1100); wr(8'h41, 32'h20 | 5);
        outs("R9 higher preempts", 1, 1);
        rd(8'h05, "R9 nested vector");
        outs("R9 nested masked", 1, 0);
        wr(8'h06, 0);
        outs("R10 back to slot7", 1, 1);
        rd(8'h05, "R10 vector after ack");
        wr(8'h06, 0); wr(8'h06, 0);
        rd(8'h05, "R10 stack empty");
        wr(8'h06, 0);
        // R3 disabled requests have no effect
        wr(8'h04, 32'hFFFF_FFFF);
        outs("R3 disabled", 0, 0);
        rd(8'h05, "R3 vector idle");
        rd(8'h01, "R4 masked zero");
        setreq(32'h0);
        outs("R8 idle", 0, 0);
        running = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule